// File: doc/BRIEF.md
# Serial Audio Frame Sync Generator

This block produces the frame timing for a time-multiplexed serial audio port. It counts bit clocks, which are presented as a one-cycle enable in the system clock domain. From that count it keeps a bit position inside the current word and a slot index inside the current frame. It drives a frame sync pulse and a strobe on the last bit of each word, and it presents the slot index. A frame holds one to four slots of 8 or 16 bits each. One slot is normal operation and more than one is network operation.

The sync pulse is either one bit clock wide or a longer pulse. The long pulse is 6 bit clocks for 8-bit words. For 16-bit words it is 13 to 16 bit clocks, chosen by a 2-bit field. The output polarity is selectable. When the external source is selected, the block watches an incoming sync pin. The active edge of that pin, after the polarity selection, realigns the counters so that the following bit clock is bit 0 of slot 0.

Top module: `audio_fsync_gen`

## Requirements
- R1: While reset is active, the counters sit at bit 0 of slot 0. With the all-zero configuration (short sync, internal source, active-high, 8-bit words, one slot) and the enable low, the outputs are fsync_out = 1, slot_idx = 0 and word_strobe = 0.
- R2: With cfg_long = 0, the sync is active for exactly the one bit clock in which bit 0 of slot 0 is presented.
- R3: With cfg_long = 1 and cfg_wide = 0, the sync is active for bits 0 to 5 of slot 0, which is 6 bit clocks, whatever value cfg_len holds.
- R4: With cfg_long = 1 and cfg_wide = 1, the sync is active for the first N bits of slot 0. cfg_len codes 0, 1, 2 and 3 give N = 13, 14, 15 and 16.
- R5: cfg_slots codes 0 to 3 select 1 to 4 slots per frame. slot_idx steps by one at each word boundary and returns to 0 after the last slot.
- R6: A word is 8 bit clocks when cfg_wide = 0 and 16 when cfg_wide = 1, so a frame is the slot count times the word length. word_strobe is high in the enable cycle that presents the last bit of a word, unless that cycle is a resynchronization.
- R7: cfg_inv = 1 inverts fsync_out, so the sync becomes active-low. With cfg_ext = 1, cfg_inv = 1 also makes a falling edge of ext_sync_in the active edge.
- R8: With cfg_ext = 1, an enable cycle in which the polarity-corrected ext_sync_in is 1 while its value at the previous enable was 0 resets the counters, so the next bit clock is bit 0 of slot 0. word_strobe stays low in that cycle. With cfg_ext = 0, ext_sync_in has no effect.
- R9: In cycles with bclk_en = 0, the bit position and slot index hold, and word_strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | One-cycle enable per bit clock |
| cfg_wide | input | 1 | Word length: 0 = 8 bits, 1 = 16 bits |
| cfg_slots | input | 2 | Slot count minus one |
| cfg_long | input | 1 | 0 = one-bit sync, 1 = long sync |
| cfg_len | input | 2 | Long sync length code for 16-bit words |
| cfg_inv | input | 1 | 1 = active-low sync |
| cfg_ext | input | 1 | 1 = realign to the external sync pin |
| ext_sync_in | input | 1 | External frame sync pin |
| fsync_out | output | 1 | Frame sync output |
| slot_idx | output | 2 | Current slot index |
| word_strobe | output | 1 | Last bit of a word |

## Verification
Any wrong bit position or slot index reaches the ports in the same cycle. A bad slot value shows on slot_idx at once. A bad bit position moves word_strobe in that cycle, and when it falls in slot 0 it also moves the edges of the sync pulse. A missed or false resynchronization therefore appears on the very next enable, as a misplaced sync or a wrong slot. A stuck edge-detect register shows on the next edge of the external pin.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int WORD_NARROW   = 8;
    localparam int WORD_WIDE     = 16;
    localparam int LONG_NARROW   = 6;
    localparam int LONG_WIDE_MIN = 13;
    localparam int SLOT_CODE_W   = 2;
    localparam int LEN_CODE_W    = 2;
    localparam int BIT_W         = $clog2(WORD_WIDE);
    localparam int LEN_W         = $clog2(WORD_WIDE + 1);

    typedef struct packed {
        logic [BIT_W-1:0]       bit_pos;
        logic [SLOT_CODE_W-1:0] slot;
    } frame_pos_t;

    typedef struct packed {
        logic prev_level;
    } edge_state_t;
endpackage

// File: rtl/afs_frame_counter.sv
module afs_frame_counter
    import afs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bclk_en,
    input  logic                   resync,
    input  logic                   cfg_wide,
    input  logic [SLOT_CODE_W-1:0] cfg_slots,
    output frame_pos_t             pos_q,
    output logic                   wrap_word
);
    frame_pos_t       pos_d;
    logic [BIT_W-1:0] last_bit;
    logic             at_last;

    always_comb begin
        last_bit  = cfg_wide ? BIT_W'(WORD_WIDE - 1) : BIT_W'(WORD_NARROW - 1);
        at_last   = (pos_q.bit_pos >= last_bit);
        wrap_word = bclk_en && !resync && at_last;
        pos_d     = pos_q;
        if (resync) begin
            pos_d = '0;
        end else if (bclk_en) begin
            if (at_last) begin
                pos_d.bit_pos = '0;
                if (pos_q.slot >= cfg_slots) begin
                    pos_d.slot = '0;
                end else begin
                    pos_d.slot = pos_q.slot + SLOT_CODE_W'(1);
                end
            end else begin
                pos_d.bit_pos = pos_q.bit_pos + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_en) |=> ($stable(pos_q.bit_pos) && $stable(pos_q.slot)));
endmodule

// File: rtl/afs_edge_detect.sv
module afs_edge_detect
    import afs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_en,
    input  logic cfg_ext,
    input  logic cfg_inv,
    input  logic sync_pin,
    output logic resync
);
    edge_state_t st_d, st_q;
    logic        level;

    always_comb begin
        level = sync_pin ^ cfg_inv;
        st_d  = st_q;
        if (bclk_en) begin
            st_d.prev_level = level;
        end
        resync = cfg_ext && bclk_en && level && !st_q.prev_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    no_double_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resync && $stable(cfg_inv)) |=> !resync);
endmodule

// File: rtl/afs_sync_shaper.sv
module afs_sync_shaper
    import afs_pkg::*;
(
    input  frame_pos_t            pos,
    input  logic                  cfg_long,
    input  logic                  cfg_wide,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic                  cfg_inv,
    output logic                  active,
    output logic                  fsync
);
    logic [LEN_W-1:0] long_len;
    logic             in_first_slot;

    always_comb begin
        long_len      = cfg_wide ? (LEN_W'(LONG_WIDE_MIN) + LEN_W'(cfg_len))
                                 : LEN_W'(LONG_NARROW);
        in_first_slot = (pos.slot == '0);
        if (cfg_long) begin
            active = in_first_slot && (LEN_W'(pos.bit_pos) < long_len);
        end else begin
            active = in_first_slot && (pos.bit_pos == '0);
        end
        fsync = active ^ cfg_inv;
    end
endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen
    import afs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bclk_en,
    input  logic                   cfg_wide,
    input  logic [SLOT_CODE_W-1:0] cfg_slots,
    input  logic                   cfg_long,
    input  logic [LEN_CODE_W-1:0]  cfg_len,
    input  logic                   cfg_inv,
    input  logic                   cfg_ext,
    input  logic                   ext_sync_in,
    output logic                   fsync_out,
    output logic [SLOT_CODE_W-1:0] slot_idx,
    output logic                   word_strobe
);
    frame_pos_t pos;
    logic       resync;
    logic       wrap_word;
    logic       active;

    afs_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_en  (bclk_en),
        .cfg_ext  (cfg_ext),
        .cfg_inv  (cfg_inv),
        .sync_pin (ext_sync_in),
        .resync   (resync)
    );

    afs_frame_counter u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_en   (bclk_en),
        .resync    (resync),
        .cfg_wide  (cfg_wide),
        .cfg_slots (cfg_slots),
        .pos_q     (pos),
        .wrap_word (wrap_word)
    );

    afs_sync_shaper u_shape (
        .pos      (pos),
        .cfg_long (cfg_long),
        .cfg_wide (cfg_wide),
        .cfg_len  (cfg_len),
        .cfg_inv  (cfg_inv),
        .active   (active),
        .fsync    (fsync_out)
    );

    assign slot_idx    = pos.slot;
    assign word_strobe = wrap_word;

    // R8
    resync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (pos.bit_pos == '0 && pos.slot == '0));

    // R6
    strobe_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_word |=> (pos.bit_pos == '0));

    // R2
    short_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_long && active && bclk_en && !resync) |=> (!active || cfg_long));
endmodule

// File: tb/tb_audio_fsync_gen.sv
module tb_audio_fsync_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_en = 1'b0;
    logic       cfg_wide = 1'b0;
    logic [1:0] cfg_slots = 2'd0;
    logic       cfg_long = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_inv = 1'b0;
    logic       cfg_ext = 1'b0;
    logic       ext_sync_in = 1'b0;
    logic       fsync_out;
    logic [1:0] slot_idx;
    logic       word_strobe;

    int checks = 0;
    int errors = 0;
    int m_bit = 0;
    int m_slot = 0;
    int m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_fsync_gen dut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .cfg_wide(cfg_wide),
        .cfg_slots(cfg_slots), .cfg_long(cfg_long), .cfg_len(cfg_len),
        .cfg_inv(cfg_inv), .cfg_ext(cfg_ext), .ext_sync_in(ext_sync_in),
        .fsync_out(fsync_out), .slot_idx(slot_idx), .word_strobe(word_strobe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare at the falling edge, then advance the model.
    task automatic step(input string tag);
        int wl, len, lvl, edge_hit, act, exp_fs, exp_st;
        @(negedge clk);
        wl  = cfg_wide ? 16 : 8;
        len = cfg_long ? (cfg_wide ? 13 + int'(cfg_len) : 6) : 1;
        act = (m_slot == 0 && m_bit < len) ? 1 : 0;
        lvl = int'(ext_sync_in ^ cfg_inv);
        edge_hit = (cfg_ext && bclk_en && lvl == 1 && m_prev == 0) ? 1 : 0;
        exp_fs = act ^ int'(cfg_inv);
        exp_st = (bclk_en && !edge_hit && m_bit >= wl - 1) ? 1 : 0;
        check(tag, int'(fsync_out), exp_fs);
        check(bclk_en ? "R5" : "R9", int'(slot_idx), m_slot);
        check(bclk_en ? "R6" : "R9", int'(word_strobe), exp_st);
        if (bclk_en) m_prev = lvl;
        if (edge_hit == 1) begin
            m_bit = 0;
            m_slot = 0;
        end else if (bclk_en) begin
            if (m_bit >= wl - 1) begin
                m_bit = 0;
                m_slot = (m_slot >= int'(cfg_slots)) ? 0 : m_slot + 1;
            end else begin
                m_bit++;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run(input string tag, input int n, input int period,
                       input int ext_period);
        for (int i = 0; i < n; i++) begin
            bclk_en = ((i % period) == 0);
            if (ext_period > 0) ext_sync_in = cfg_inv ^ ((i % ext_period) < 2);
            else ext_sync_in = cfg_inv ^ ((i % 5) == 0);
            step(tag);
        end
        bclk_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with default configuration
        #(CLK_PERIOD * 3);
        check("R1", int'(fsync_out), 1);
        check("R1", int'(slot_idx), 0);
        check("R1", int'(word_strobe), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step("R1");
        // R2: short sync, narrow words, one slot then two
        run("R2", 40, 1, 0);
        cfg_slots = 2'd1;
        run("R2", 60, 1, 0);
        // R3: long sync narrow ignores length field
        cfg_long = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cfg_len = 2'(c);
            run("R3", 70, 2, 0);
        end
        // R4: long sync wide, every length code
        cfg_wide = 1'b1;
        cfg_slots = 2'd1;
        for (int c = 0; c < 4; c++) begin
            cfg_len = 2'(c);
            run("R4", 80, 1, 0);
        end
        // R5/R6: three slots then four, short sync, wide words
        cfg_long = 1'b0;
        cfg_slots = 2'd2;
        run("R6", 120, 1, 0);
        cfg_slots = 2'd3;
        run("R5", 150, 3, 0);
        // R7: inverted polarity, narrow long sync, four slots
        cfg_wide = 1'b0;
        cfg_long = 1'b1;
        cfg_inv = 1'b1;
        run("R7", 100, 1, 0);
        // R9: enable held low
        run("R9", 12, 1000, 0);
        for (int i = 0; i < 10; i++) begin
            bclk_en = 1'b0;
            step("R9");
        end
        // R8: external resync, both polarities and sparse enables
        cfg_ext = 1'b1;
        cfg_inv = 1'b0;
        cfg_slots = 2'd1;
        run("R8", 120, 1, 21);
        cfg_inv = 1'b1;
        run("R8", 120, 1, 27);
        cfg_wide = 1'b1;
        run("R8", 200, 3, 40);
        // R8: with internal source the pin has no effect
        cfg_ext = 1'b0;
        run("R8", 100, 1, 13);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule